// File: doc/BRIEF.md
# Interrupt request sequencer

This block sits beside a CPU core and decides on which instruction step the core takes a pending non-maskable interrupt (NMI) or a maskable interrupt request (IRQ). The core pulses `step_i` once per instruction step, reports its interrupt-mask flag and whether it is parked in a wait-for-interrupt state. The block answers with single-cycle `take_nmi_o` and `take_irq_o` pulses. It also gives a `wake_o` pulse that tells the core to leave the wait state and move its program counter past the wait instruction.

IRQ requests come from a small set of sources. Each source can be raised or dropped on its own, and the set of live sources is visible on `src_active_o`. A raised IRQ waits a fixed three steps before it can be taken, unless the core is waiting. If the mask flag holds it off, the IRQ stays parked one step short of being taken rather than being lost. An NMI counts down a delay that is loaded with the trigger. On any step it is examined ahead of the IRQ.

Top module: `intr_seq`

## Requirements
- R1: After reset `take_nmi_o`, `take_irq_o` and `wake_o` are 0, `src_active_o` is all zeros, and no interrupt is pending.
- R2: In a cycle with `src_set_i` = S and `src_clr_i` = C, the next `src_active_o` is (old & ~C) | S. Clearing removes only the named bits, and a set wins over a clear of the same bit.
- R3: A cycle with any `src_set_i` bit high raises the IRQ: it marks the IRQ pending and loads a delay of 3. With the mask clear, the IRQ is not disabled and a source active, `take_irq_o` pulses in the cycle after the 4th step that follows the raise, and not after the first three.
- R4: A step that brings the delay to 0 while `mask_i` is 1 reloads the delay to 1, and no IRQ is taken while masked. After k masked steps followed by unmasked ones, the IRQ is taken on unmasked step number max(3-k,1)+1.
- R5: A raise while `wait_i` is 1 gives a `wake_o` pulse in the next cycle and forces the delay to 0, so the IRQ is taken on the first step.
- R6: A step that sees delay 0 with no source active, or with `irq_dis_i` = 1, clears the pending IRQ without taking it. No later step takes an IRQ until a new raise.
- R7: While the IRQ is pending with delay 0, a source active, the IRQ not disabled and the mask clear, every step takes the IRQ again.
- R8: `nmi_trig_i` loads an NMI delay of D = `nmi_dly_i` (D = 0 acts as 1). `take_nmi_o` pulses once, in the cycle after the D-th following step, and never again without a new trigger.
- R9: On the step where the NMI is taken, IRQ handling is skipped: no IRQ is taken and its delay holds. A due IRQ is taken on the next step.
- R10: Cycles without `step_i` change no delay, and no take pulse follows them.
- R11: `wake_o` pulses in the cycle after a step in which `wait_i` is 1 and either the NMI is taken or the pending IRQ is examined at delay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One pulse per instruction step |
| wait_i | input | 1 | Core is in the wait-for-interrupt state |
| mask_i | input | 1 | Core interrupt-mask flag (1 = IRQ held off) |
| irq_dis_i | input | 1 | Global IRQ disable |
| src_set_i | input | N_SRC | Raise the IRQ sources whose bits are 1 |
| src_clr_i | input | N_SRC | Drop the IRQ sources whose bits are 1 |
| nmi_trig_i | input | 1 | Arm an NMI |
| nmi_dly_i | input | NMI_W | NMI delay in steps, loaded on trigger |
| take_nmi_o | output | 1 | Core takes NMI now (one cycle) |
| take_irq_o | output | 1 | Core takes IRQ now (one cycle) |
| wake_o | output | 1 | End the wait state and advance the program counter |
| src_active_o | output | N_SRC | Currently active IRQ sources |

## Verification
The assertions assume that the core holds `mask_i`, `irq_dis_i` and `wait_i` steady from the edge of one step to the next. They also assume that the take pulses are read in the cycle after the step that caused them. The bench changes these level inputs only between edges and drives one step per cycle at most. It sweeps every pair of source set and clear patterns, every mask-release point for the parked IRQ, and NMI delays 0 to 15. Its expected step counts come from the delay arithmetic in the requirements.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int unsigned IRQ_DLY = 3;
  localparam int unsigned IRQ_CW  = $clog2(IRQ_DLY + 1);
endpackage

// File: rtl/iseq_src_reg.sv
module iseq_src_reg #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] active_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       active_o[g] <= 1'b0;
      else if (set_i[g]) active_o[g] <= 1'b1;
      else if (clr_i[g]) active_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/iseq_nmi.sv
module iseq_nmi #(
  parameter int unsigned NMI_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             trig_i,
  input  logic [NMI_W-1:0] dly_i,
  output logic             fire_o
);
  localparam logic [NMI_W-1:0] ONE = NMI_W'(1);

  logic             pend_q;
  logic [NMI_W-1:0] cnt_q;

  // trigger wins over a step in the same cycle
  assign fire_o = step_i & pend_q & ~trig_i & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i) begin
      pend_q <= 1'b1;
      cnt_q  <= (dly_i == '0) ? ONE : dly_i;
    end else if (step_i && pend_q) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/iseq_irq.sv
module iseq_irq
  import intr_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  input  logic step_i,
  input  logic wait_i,
  input  logic mask_i,
  input  logic dis_i,
  input  logic any_act_i,
  output logic take_o,
  output logic wake_o
);
  localparam logic [IRQ_CW-1:0] LOAD = IRQ_CW'(IRQ_DLY);
  localparam logic [IRQ_CW-1:0] ONE  = IRQ_CW'(1);

  logic              pend_q;
  logic [IRQ_CW-1:0] cnt_q;
  logic              eval, at_zero, drop;

  assign eval    = step_i & pend_q & ~raise_i;
  assign at_zero = eval & (cnt_q == '0);
  assign take_o  = at_zero & any_act_i & ~dis_i & ~mask_i;
  assign drop    = at_zero & (~any_act_i | dis_i);
  assign wake_o  = wait_i & (raise_i | at_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (raise_i) begin
      pend_q <= 1'b1;
      cnt_q  <= wait_i ? '0 : LOAD;
    end else if (eval) begin
      if (cnt_q == '0) begin
        if (drop) pend_q <= 1'b0;
      end else if (cnt_q == ONE && mask_i) begin
        cnt_q <= ONE;  // park one step short while masked
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned NMI_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wait_i,
  input  logic             mask_i,
  input  logic             irq_dis_i,
  input  logic [N_SRC-1:0] src_set_i,
  input  logic [N_SRC-1:0] src_clr_i,
  input  logic             nmi_trig_i,
  input  logic [NMI_W-1:0] nmi_dly_i,
  output logic             take_nmi_o,
  output logic             take_irq_o,
  output logic             wake_o,
  output logic [N_SRC-1:0] src_active_o
);
  logic nmi_fire, irq_take, irq_wake;

  iseq_src_reg #(.N_SRC(N_SRC)) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(src_set_i), .clr_i(src_clr_i),
    .active_o(src_active_o)
  );

  iseq_nmi #(.NMI_W(NMI_W)) u_nmi (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .trig_i(nmi_trig_i),
    .dly_i(nmi_dly_i), .fire_o(nmi_fire)
  );

  // NMI goes first: its firing step is withheld from the IRQ path
  iseq_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .raise_i(|src_set_i),
    .step_i(step_i & ~nmi_fire), .wait_i(wait_i), .mask_i(mask_i),
    .dis_i(irq_dis_i), .any_act_i(|src_active_o),
    .take_o(irq_take), .wake_o(irq_wake)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_nmi_o <= 1'b0;
      take_irq_o <= 1'b0;
      wake_o     <= 1'b0;
    end else begin
      take_nmi_o <= nmi_fire;
      take_irq_o <= irq_take;
      wake_o     <= irq_wake | (nmi_fire & wait_i);
    end
  end
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
  parameter int unsigned N_SRC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic             wait_i,
  input logic             mask_i,
  input logic             irq_dis_i,
  input logic [N_SRC-1:0] src_set_i,
  input logic [N_SRC-1:0] src_clr_i,
  input logic             take_nmi_o,
  input logic             take_irq_o,
  input logic             wake_o,
  input logic [N_SRC-1:0] src_active_o
);
  p_nmi_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_nmi_o && take_irq_o));

  p_irq_unmasked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> ($past(step_i) && !$past(mask_i) && !$past(irq_dis_i)));

  p_nmi_on_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_nmi_o |-> $past(step_i));

  p_wait_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|src_set_i) && wait_i) |=> wake_o);

  p_raise_delays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_set_i) |=> !take_irq_o);

  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_set_i) |=> ((src_active_o & $past(src_set_i)) == $past(src_set_i)));

  p_clr_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(src_clr_i & ~src_set_i)) |=>
      ((src_active_o & $past(src_clr_i & ~src_set_i)) == '0));

  p_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(wait_i) && ($past(step_i) || $past(|src_set_i))));
endmodule

bind intr_seq intr_seq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .wait_i(wait_i),
  .mask_i(mask_i), .irq_dis_i(irq_dis_i), .src_set_i(src_set_i),
  .src_clr_i(src_clr_i), .take_nmi_o(take_nmi_o), .take_irq_o(take_irq_o),
  .wake_o(wake_o), .src_active_o(src_active_o)
);

// File: tb/tb_intr_seq.sv
`timescale 1ns/1ps
module tb_intr_seq;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 0, wt = 0, msk = 0, dis = 0, trig = 0;
  logic [N-1:0] set = '0, clr = '0;
  logic [W-1:0] dly = '0;
  logic tn, ti, wk;
  logic [N-1:0] act;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intr_seq #(.N_SRC(N), .NMI_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .wait_i(wt), .mask_i(msk),
    .irq_dis_i(dis), .src_set_i(set), .src_clr_i(clr), .nmi_trig_i(trig),
    .nmi_dly_i(dly), .take_nmi_o(tn), .take_irq_o(ti), .wake_o(wk),
    .src_active_o(act)
  );

  task automatic chk(string r, int a, int e);
    vecs++;
    if (a != e) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  task automatic cyc(logic st, logic [N-1:0] s, logic [N-1:0] c,
                     logic tg = 0, logic [W-1:0] d = '0);
    @(negedge clk);
    step = st; set = s; clr = c; trig = tg; dly = d;
    @(posedge clk); #1;
    step = 0; set = '0; clr = '0; trig = 0;
  endtask

  task automatic do_reset();
    wt = 0; msk = 0; dis = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    #1;
    chk("R1 take_nmi", tn, 0); chk("R1 take_irq", ti, 0);
    chk("R1 wake", wk, 0);     chk("R1 active", act, 0);
    // R1: nothing pending, steps take nothing
    for (int i = 0; i < 5; i++) begin cyc(1, 0, 0); chk("R1 idle", ti | tn, 0); end

    // R2 sweep of set/clear patterns
    for (int a = 0; a < 16; a++)
      for (int c = 0; c < 16; c++) begin
        cyc(0, 0, '1);
        cyc(0, N'(a), 0);
        chk("R2 set", act, a);
        cyc(0, 0, N'(c));
        chk("R2 clr", act, a & ~c);
        cyc(0, N'(c), N'(c));
        chk("R2 set_wins", act, (a & ~c) | c);
      end

    // R3 / R7 / R10
    do_reset();
    cyc(0, 4'b0001, 0);
    for (int k = 1; k <= 3; k++) begin
      cyc(1, 0, 0); chk("R3 early", ti, 0);
      cyc(0, 0, 0); chk("R10 nostep", ti, 0);
    end
    cyc(1, 0, 0); chk("R3 take4", ti, 1);
    cyc(0, 0, 0); chk("R3 pulse", ti, 0);
    cyc(1, 0, 0); chk("R7 again", ti, 1);
    cyc(1, 0, 0); chk("R7 again2", ti, 1);
    // R6: no source active at delay zero
    cyc(0, 0, 4'b0001);
    cyc(1, 0, 0); chk("R6 noact", ti, 0);
    // R6: globally disabled
    do_reset();
    cyc(0, 4'b0100, 0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0);
    dis = 1; cyc(1, 0, 0); chk("R6 dis", ti, 0);
    dis = 0;
    for (int k = 0; k < 6; k++) begin cyc(1, 0, 0); chk("R6 dropped", ti, 0); end

    // R4 sweep of mask release point
    for (int k = 0; k <= 6; k++) begin
      do_reset();
      cyc(0, 4'b0010, 0);
      msk = 1;
      for (int j = 0; j < k; j++) begin cyc(1, 0, 0); chk("R4 masked", ti, 0); end
      msk = 0;
      n = 0;
      for (int j = 1; j <= 8; j++) begin
        cyc(1, 0, 0);
        if (ti && n == 0) n = j;
      end
      chk("R4 release", n, ((3 - k) > 1 ? (3 - k) : 1) + 1);
    end

    // R5 / R11 wait state
    do_reset();
    wt = 1;
    cyc(0, 4'b1000, 0); chk("R5 wake", wk, 1); chk("R5 notake", ti, 0);
    cyc(0, 0, 0);       chk("R5 wake_pulse", wk, 0);
    cyc(1, 0, 0);       chk("R5 take1", ti, 1); chk("R11 wake_irq", wk, 1);
    wt = 0;

    // R8 NMI delay sweep, with wait held for R11
    for (int d = 0; d < 16; d++) begin
      do_reset();
      wt = 1;
      cyc(0, 0, 0, 1, W'(d));
      n = 0;
      for (int j = 1; j <= 20; j++) begin
        cyc(1, 0, 0);
        chk("R11 nmi_wake", wk, tn);
        if (tn) begin
          if (n == 0) n = j; else n = 99;
        end
      end
      chk("R8 nmi_step", n, (d == 0) ? 1 : d);
      wt = 0;
    end

    // R9 NMI priority over a due IRQ
    do_reset();
    cyc(0, 4'b0001, 0, 1, W'(4));
    for (int k = 0; k < 3; k++) cyc(1, 0, 0);
    cyc(1, 0, 0); chk("R9 nmi", tn, 1); chk("R9 irq_held", ti, 0);
    cyc(1, 0, 0); chk("R9 irq_next", ti, 1); chk("R9 nmi_once", tn, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule